// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block turns a single-cycle watchdog expiry strobe into a timed reset pulse on an external pin. The pulse length is counted in microseconds against a 1 us tick. The tick comes from dividing the system clock by a fixed parameter, and the divider restarts when each pulse begins.

A single 32-bit configuration word, decoded at offset 0x18 of the watchdog register window, sets up the block. The low bits hold the pulse duration minus one. Two output properties sit in the top bits of the word: the asserted level and whether the pin is driven push-pull or open-drain. Software changes these two properties only by writing one of four key bytes into bits 31:24. Any other top byte leaves them alone, and the duration field of that same write is still taken.

The block has two outputs. One is the pin level, with the polarity applied. The other is an output-enable that models the pad driver: it stays on in push-pull mode, and in open-drain mode it turns on only while the pulse is asserted.

Top module: `wdt_ext_pulse`

## Requirements
- R1: After reset the duration field is 0xFF, polarity is active low and drive mode is open-drain, so the idle pin level is 1 and the output-enable is 0.
- R2: A read at offset 0x18 returns bit 31 = polarity (1 = active high), bit 30 = drive mode (1 = push-pull) and bits DUR_W-1:0 = duration. All other bits read 0, and reads at any other offset return 0. Write bits DUR_W..29 are not stored.
- R3: A write whose bits 31:24 equal 0xA5 selects active high, and 0x5A selects active low.
- R4: A write whose bits 31:24 equal 0xA8 selects push-pull, and 0x8A selects open-drain.
- R5: A write with any other value in bits 31:24 leaves polarity and drive mode unchanged, and still stores the duration field.
- R6: A timeout strobe sampled while idle asserts the pulse from the next clock. The pulse lasts exactly (N+1) x CLKS_PER_US clock cycles, where N is the stored duration.
- R7: A timeout strobe that arrives while a pulse is in progress is ignored and does not extend the pulse.
- R8: A duration written during a pulse does not change that pulse. It applies from the next pulse.
- R9: The pin shows the active level while the pulse is asserted and the opposite level otherwise.
- R10: In push-pull mode the output-enable is always 1. In open-drain mode it is 1 only while the pulse is asserted.
- R11: Writes at any offset other than 0x18 change no configuration state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| wdt_timeout | input | 1 | One-cycle watchdog expiry strobe |
| ext_rst_o | output | 1 | Reset pin level, polarity applied |
| ext_rst_oe_o | output | 1 | Pin output-enable |

## Verification
The bench builds the block with DUR_W = 8 and CLKS_PER_US = 3. With these values the full duration range, including the 0xFF reset value, gives pulses of at most 768 cycles, so every pulse length can be measured to the exact cycle. The narrow field also makes writes with set bits above bit 7 a real truncation case. A divider of 3 keeps the tick restart visible, because a pulse that started mid-count would come out one or two cycles short.

// File: rtl/wdtp_pkg.sv
package wdtp_pkg;

  localparam logic [7:0] KEY_ACT_HIGH  = 8'hA5;
  localparam logic [7:0] KEY_ACT_LOW   = 8'h5A;
  localparam logic [7:0] KEY_PUSH_PULL = 8'hA8;
  localparam logic [7:0] KEY_OPEN_DRN  = 8'h8A;

  typedef struct packed {
    logic pol_we;
    logic pol_val;
    logic drv_we;
    logic drv_val;
  } key_cmd_t;

  // Turn a top byte into update enables for the two output properties.
  function automatic key_cmd_t decode_key(input logic [7:0] top);
    key_cmd_t c;
    c = '0;
    case (top)
      KEY_ACT_HIGH:  begin c.pol_we = 1'b1; c.pol_val = 1'b1; end
      KEY_ACT_LOW:   begin c.pol_we = 1'b1; c.pol_val = 1'b0; end
      KEY_PUSH_PULL: begin c.drv_we = 1'b1; c.drv_val = 1'b1; end
      KEY_OPEN_DRN:  begin c.drv_we = 1'b1; c.drv_val = 1'b0; end
      default:       c = '0;
    endcase
    return c;
  endfunction

  // Pin level: active level while pulsing, inverse when idle.
  function automatic logic pin_level(input logic pulsing, input logic act_high);
    return pulsing ? act_high : ~act_high;
  endfunction

  // Pad enable: push-pull drives always, open-drain only while pulsing.
  function automatic logic pin_enable(input logic pulsing, input logic push_pull);
    return push_pull | pulsing;
  endfunction

endpackage

// File: rtl/wdtp_cfg_reg.sv
module wdtp_cfg_reg
  import wdtp_pkg::*;
#(
  parameter int DUR_W   = 20,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h18,
  parameter int RST_DUR = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wr_hit_o,
  output logic [DUR_W-1:0]  dur_o,
  output logic              act_high_o,
  output logic              push_pull_o
);

  localparam logic [DUR_W-1:0] DUR_RST = DUR_W'(RST_DUR);

  logic       sel;
  key_cmd_t   cmd;

  assign sel      = (bus_addr == REG_OFS);
  assign wr_hit_o = bus_wen && sel;
  assign cmd      = decode_key(bus_wdata[31:24]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_o       <= DUR_RST;
      act_high_o  <= 1'b0;
      push_pull_o <= 1'b0;
    end else if (wr_hit_o) begin
      dur_o <= bus_wdata[DUR_W-1:0];
      if (cmd.pol_we) act_high_o  <= cmd.pol_val;
      if (cmd.drv_we) push_pull_o <= cmd.drv_val;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel) begin
      bus_rdata[31]        = act_high_o;
      bus_rdata[30]        = push_pull_o;
      bus_rdata[DUR_W-1:0] = dur_o;
    end
  end

endmodule

// File: rtl/wdtp_tick_gen.sv
module wdtp_tick_gen #(
  parameter int CLKS_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);

  generate
    if (CLKS_PER_US == 1) begin : g_direct
      assign tick = run && !restart;
    end else begin : g_div
      localparam int PW = $clog2(CLKS_PER_US);
      localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);
      logic [PW-1:0] pre;

      assign tick = run && (pre == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre <= '0;
        else if (restart) pre <= '0;
        else if (run)     pre <= tick ? '0 : pre + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/wdtp_pulse_ctrl.sv
module wdtp_pulse_ctrl #(
  parameter int DUR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             tick,
  input  logic [DUR_W-1:0] dur_cfg,
  output logic             active_o,
  output logic             start_o,
  output logic             end_o,
  output logic [DUR_W-1:0] dur_lat_o
);

  logic [DUR_W-1:0] us_cnt;

  assign start_o = strobe && !active_o;
  assign end_o   = active_o && tick && (us_cnt == dur_lat_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o  <= 1'b0;
      us_cnt    <= '0;
      dur_lat_o <= '0;
    end else if (start_o) begin
      active_o  <= 1'b1;
      us_cnt    <= '0;
      dur_lat_o <= dur_cfg;
    end else if (end_o) begin
      active_o <= 1'b0;
      us_cnt   <= '0;
    end else if (active_o && tick) begin
      us_cnt <= us_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdtp_out_stage.sv
module wdtp_out_stage
  import wdtp_pkg::*;
(
  input  logic pulsing,
  input  logic act_high,
  input  logic push_pull,
  output logic pin_o,
  output logic pin_oe_o
);

  assign pin_o    = pin_level(pulsing, act_high);
  assign pin_oe_o = pin_enable(pulsing, push_pull);

endmodule

// File: rtl/wdt_ext_pulse.sv
module wdt_ext_pulse #(
  parameter int DUR_W       = 20,
  parameter int CLKS_PER_US = 100,
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h18,
  parameter int RST_DUR     = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wdt_timeout,
  output logic              ext_rst_o,
  output logic              ext_rst_oe_o
);

  // Named internal events, visible to the bound checker.
  logic             wr_hit;
  logic [DUR_W-1:0] dur_q;
  logic             act_high_q;
  logic             push_pull_q;
  logic             us_tick;
  logic             pulse_active;
  logic             pulse_start;
  logic             pulse_end;
  logic [DUR_W-1:0] dur_lat;

  wdtp_cfg_reg #(
    .DUR_W(DUR_W), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS), .RST_DUR(RST_DUR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wr_hit_o(wr_hit), .dur_o(dur_q),
    .act_high_o(act_high_q), .push_pull_o(push_pull_q)
  );

  wdtp_tick_gen #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(pulse_start),
    .run(pulse_active), .tick(us_tick)
  );

  wdtp_pulse_ctrl #(.DUR_W(DUR_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .strobe(wdt_timeout), .tick(us_tick),
    .dur_cfg(dur_q), .active_o(pulse_active), .start_o(pulse_start),
    .end_o(pulse_end), .dur_lat_o(dur_lat)
  );

  wdtp_out_stage u_out (
    .pulsing(pulse_active), .act_high(act_high_q), .push_pull(push_pull_q),
    .pin_o(ext_rst_o), .pin_oe_o(ext_rst_oe_o)
  );

endmodule

// File: rtl/wdtp_checker.sv
module wdtp_checker #(
  parameter int DUR_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_hit,
  input logic [7:0]       key_byte,
  input logic [DUR_W-1:0] wr_dur,
  input logic [DUR_W-1:0] dur_q,
  input logic             act_high_q,
  input logic             push_pull_q,
  input logic             strobe,
  input logic             active,
  input logic             tick,
  input logic             pulse_end,
  input logic [DUR_W-1:0] dur_lat,
  input logic             pin,
  input logic             pin_oe
);

  logic key_any;
  assign key_any = (key_byte == 8'hA5) || (key_byte == 8'h5A) ||
                   (key_byte == 8'hA8) || (key_byte == 8'h8A);

  p_pol_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && key_byte == 8'hA5) |=> act_high_q);
  p_pol_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && key_byte == 8'h5A) |=> !act_high_q);
  p_drv_pp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && key_byte == 8'hA8) |=> push_pull_q);
  p_drv_od_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && key_byte == 8'h8A) |=> !push_pull_q);
  p_key_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !key_any) |=> ($stable(act_high_q) && $stable(push_pull_q)));
  p_dur_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (dur_q == $past(wr_dur)));
  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !active) |=> active);
  p_end_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> active);
  p_ignore_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && strobe && !pulse_end) |=> (active && $stable(dur_lat)));
  p_lat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pulse_end) |=> $stable(dur_lat));
  p_level_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pin == act_high_q));
  p_level_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (pin != act_high_q));
  p_oe_pp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push_pull_q |-> pin_oe);
  p_oe_od_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_pull_q && !active) |-> !pin_oe);
  p_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(dur_q) && $stable(act_high_q) && $stable(push_pull_q)));

endmodule

bind wdt_ext_pulse wdtp_checker #(.DUR_W(DUR_W)) u_wdtp_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .key_byte(bus_wdata[31:24]),
  .wr_dur(bus_wdata[DUR_W-1:0]), .dur_q(dur_q), .act_high_q(act_high_q),
  .push_pull_q(push_pull_q), .strobe(wdt_timeout), .active(pulse_active),
  .tick(us_tick), .pulse_end(pulse_end), .dur_lat(dur_lat),
  .pin(ext_rst_o), .pin_oe(ext_rst_oe_o)
);

// File: tb/tb_wdt_ext_pulse.sv
module tb_wdt_ext_pulse;

  localparam int DUR_W = 8;
  localparam int CPU   = 3;
  localparam int MASK  = (1 << DUR_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [7:0]  bus_addr = 8'h18;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_timeout = 1'b0;
  logic        ext_rst_o;
  logic        ext_rst_oe_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wdt_ext_pulse #(.DUR_W(DUR_W), .CLKS_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_timeout(wdt_timeout),
    .ext_rst_o(ext_rst_o), .ext_rst_oe_o(ext_rst_oe_o)
  );

  // Behavioural reference model.
  int m_dur;
  bit m_pol, m_drv, m_act, m_start;
  int m_rem;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dur = 255; m_pol = 0; m_drv = 0; m_act = 0; m_rem = 0;
    end else begin
      m_start = wdt_timeout && !m_act;
      if (m_act) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) m_act = 0;
      end
      if (m_start) begin
        m_act = 1;
        m_rem = (m_dur + 1) * CPU;
      end
      if (bus_wen && bus_addr == 8'h18) begin
        m_dur = int'(bus_wdata) & MASK;
        if (bus_wdata[31:24] == 8'hA5) m_pol = 1;
        if (bus_wdata[31:24] == 8'h5A) m_pol = 0;
        if (bus_wdata[31:24] == 8'hA8) m_drv = 1;
        if (bus_wdata[31:24] == 8'h8A) m_drv = 0;
      end
    end
  end

  // Compare against the model on every clock.
  always @(negedge clk) begin
    if (rst_n) begin
      checks = checks + 2;
      if (ext_rst_o !== (m_act ? m_pol : !m_pol)) begin
        errors++;
        $display("FAIL R9/R6 pin level at %0t: got %0b exp %0b", $time, ext_rst_o,
                 m_act ? m_pol : !m_pol);
      end
      if (ext_rst_oe_o !== (m_drv || m_act)) begin
        errors++;
        $display("FAIL R10 output-enable at %0t: got %0b exp %0b", $time, ext_rst_oe_o,
                 m_drv || m_act);
      end
    end
  end

  task automatic check_val(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h exp 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0; bus_addr = 8'h18;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input int exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check_val(tag, int'(bus_rdata), exp);
    bus_addr = 8'h18;
  endtask

  // Fire a strobe and count asserted cycles; at count poke_at optionally
  // re-strobe and/or write wd to the config register.
  task automatic run_pulse(input logic act, input int poke_at, input bit re_strobe,
                           input bit do_wr, input logic [31:0] wd, output int len);
    @(negedge clk);
    wdt_timeout = 1'b1;
    @(negedge clk);
    wdt_timeout = 1'b0;
    len = 0;
    while (ext_rst_o === act && len < 5000) begin
      if (len == poke_at) begin
        wdt_timeout = re_strobe;
        if (do_wr) begin bus_wen = 1'b1; bus_wdata = wd; end
      end
      len++;
      @(negedge clk);
      wdt_timeout = 1'b0;
      bus_wen = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 layout
    rd(8'h18, "R1 reset readback", 32'h0000_00FF);
    check_val("R1 idle pin level", int'(ext_rst_o), 1);
    check_val("R1 idle output-enable", int'(ext_rst_oe_o), 0);

    // R6 default pulse
    run_pulse(1'b0, -1, 0, 0, '0, len);
    check_val("R6 default pulse length", len, 256 * CPU);

    // R5 non-key byte, shortest pulse
    wr(8'h18, 32'h0000_0000);
    rd(8'h18, "R5 plain write readback", 32'h0000_0000);
    run_pulse(1'b0, -1, 0, 0, '0, len);
    check_val("R6 zero-duration pulse", len, CPU);

    // R3 active high
    wr(8'h18, 32'hA500_0005);
    rd(8'h18, "R3 active-high key", 32'h8000_0005);
    check_val("R9 idle level active-high", int'(ext_rst_o), 0);
    run_pulse(1'b1, -1, 0, 0, '0, len);
    check_val("R6/R9 active-high pulse length", len, 6 * CPU);

    // R4 push-pull
    wr(8'h18, 32'hA800_0005);
    rd(8'h18, "R4 push-pull key", 32'hC000_0005);
    check_val("R10 push-pull idle enable", int'(ext_rst_oe_o), 1);

    // R5 other top byte keeps properties
    wr(8'h18, 32'h7700_0009);
    rd(8'h18, "R5 non-key keeps properties", 32'hC000_0009);

    wr(8'h18, 32'h5A00_0009);
    rd(8'h18, "R3 active-low key", 32'h4000_0009);
    wr(8'h18, 32'h8A00_0009);
    rd(8'h18, "R4 open-drain key", 32'h0000_0009);

    // R11 other offset
    wr(8'h14, 32'hA500_0001);
    rd(8'h18, "R11 foreign write ignored", 32'h0000_0009);
    rd(8'h14, "R2 foreign offset reads zero", 0);

    // R2 truncation of wide duration
    wr(8'h18, 32'h0000_0FFF);
    rd(8'h18, "R2 duration truncated", 32'h0000_00FF);

    // R7 strobe mid-pulse
    wr(8'h18, 32'h0000_0009);
    run_pulse(1'b0, 10, 1, 0, '0, len);
    check_val("R7 re-strobe ignored", len, 10 * CPU);

    // R8 duration written mid-pulse
    bus_addr = 8'h18;
    run_pulse(1'b0, 7, 0, 1, 32'h0000_0002, len);
    check_val("R8 current pulse unchanged", len, 10 * CPU);
    rd(8'h18, "R8 new duration stored", 32'h0000_0002);
    run_pulse(1'b0, -1, 0, 0, '0, len);
    check_val("R8 next pulse uses new duration", len, 3 * CPU);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule